// File: doc/BRIEF.md
# ADC Result Window Monitor

This block sits beside a multi-channel converter and watches its stream of results. Four independent monitor units each follow one converter channel, chosen by software. Each unit compares the high byte of every matching result against its own upper and lower limit. When a limit is crossed, the unit sets a sticky status bit, according to its trigger mode. A masked OR of all status bits drives a single interrupt line.

Software programs the units through a small write port of six addressed words. Two words hold the limits, packed two units to a word. One control word holds every unit's trigger mode and source channel. One word holds the detection enables, one holds the interrupt mask, and one clears status when 1 is written to a bit. Raw comparison flags are brought out apart from the status bits, so the current window condition can be seen whether or not interrupts are enabled.

Top module: `adc_window_monitor`

## Requirements
- R1: After reset every limit, mode, source, enable, mask, raw flag and status bit is zero, and `irq` is low.
- R2: Address 0 holds the limits of units 0 and 1, and address 1 holds those of units 2 and 3. The odd unit sits in bits 31:16 and the even unit in bits 15:0. Within a unit's 16 bits, the upper limit is bits 15:8 and the lower limit is bits 7:0. Both limits are signed two's complement.
- R3: Address 2 is the control word. Unit u's trigger mode is bits 2u+1:2u, coded 0 level, 1 rising, 2 falling, 3 both edges. Unit u's source channel is bits 8+4u+3:8+4u. At address 3, unit u's lower enable is bit 2u and its upper enable is bit 2u+1. Writes to addresses 6 and 7 change nothing.
- R4: Only the signed top byte of the result, `resData[15:8]`, is compared. The upper condition is top byte > upper limit, and the lower condition is top byte < lower limit. A top byte equal to a limit meets neither condition.
- R5: A unit evaluates only on a clock where `resValid` is high and `resChan` equals its source channel. On any other clock its raw flags and its status bits keep their values, unless a clear is written.
- R6: On an evaluating clock, each raw flag becomes (its enable AND its condition). The flag is visible one clock later, and the interrupt mask has no effect on it.
- R7: In level mode an enabled condition sets the matching status bit on every evaluating sample where the condition holds.
- R8: In rising mode status is set when the enabled condition goes from false to true against the previous raw flag. In falling mode it is set when the condition goes from true to false. In both-edges mode it is set on either change.
- R9: A detection whose enable is 0 never sets its status bit.
- R10: Writing address 5 clears status bits. Bit 2u clears unit u's lower status and bit 2u+1 clears its upper status. Writing 0 to a bit leaves that status bit unchanged, and a set on the same clock wins over the clear.
- R11: `irq` is the OR of every status bit ANDed with its mask bit at address 4, laid out as at address 5. `irq` follows the registered status and mask with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resValid | input | 1 | Conversion result strobe |
| resChan | input | 4 | Channel index of the result |
| resData | input | 16 | Signed conversion result |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register write address |
| cfgWdata | input | 32 | Register write data |
| rawLo | output | 4 | Per-unit raw lower-limit flag |
| rawHi | output | 4 | Per-unit raw upper-limit flag |
| statLo | output | 4 | Per-unit lower status |
| statHi | output | 4 | Per-unit upper status |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions check, on every clock, that flags and status hold when a unit is not evaluating. They also check that disabled detections leave their raw flag low, that a lone clear empties a status bit and that status is otherwise sticky, that level mode sets status whenever the condition holds, and that `irq` never rises without some status bit set. Only the bench's sweeps can show the rest: the field positions, the signed comparisons at their exact boundaries, the edge modes against a history of samples, and the mask layout. These sweeps cycle every trigger mode, several enable and mask patterns, and all 256 top-byte values over rotating channels.

// File: rtl/adcwm_pkg.sv
package adcwm_pkg;
  localparam int NUM_UNITS = 4;
  localparam int CHAN_W    = 4;
  localparam int LIM_W     = 8;
  localparam int RES_W     = 16;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 32;
  localparam int PAIR_W    = 2 * LIM_W;
  localparam int FLAG_W    = 2 * NUM_UNITS;
  localparam int CTRL_W    = 2 * NUM_UNITS + CHAN_W * NUM_UNITS;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd5;

  typedef enum logic [1:0] {
    TRG_LEVEL = 2'd0,
    TRG_RISE  = 2'd1,
    TRG_FALL  = 2'd2,
    TRG_BOTH  = 2'd3
  } trig_e;

  typedef struct packed {
    logic [NUM_UNITS-1:0] evalStb;
    logic [NUM_UNITS-1:0] clrLo;
    logic [NUM_UNITS-1:0] clrHi;
  } strobes_t;

  function automatic logic edgeHit(trig_e mode, logic nowVal, logic oldVal);
    case (mode)
      TRG_LEVEL: edgeHit = nowVal;
      TRG_RISE:  edgeHit = nowVal & ~oldVal;
      TRG_FALL:  edgeHit = ~nowVal & oldVal;
      default:   edgeHit = nowVal ^ oldVal;
    endcase
  endfunction
endpackage

// File: rtl/adcwm_ctrl.sv
module adcwm_ctrl
  import adcwm_pkg::*;
#(
  parameter int N_UNITS = NUM_UNITS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [ADDR_W-1:0]           cfgAddr,
  input  logic [DATA_W-1:0]           cfgWdata,
  input  logic                        resValid,
  input  logic [CHAN_W-1:0]           resChan,
  output logic [N_UNITS-1:0][LIM_W-1:0] upLim,
  output logic [N_UNITS-1:0][LIM_W-1:0] loLim,
  output logic [N_UNITS-1:0][1:0]     trigSel,
  output logic [N_UNITS-1:0]          enLo,
  output logic [N_UNITS-1:0]          enHi,
  output logic [FLAG_W-1:0]           intMask,
  output strobes_t                    stb
);
  localparam int N_PAIRS = N_UNITS / 2;

  logic [N_PAIRS-1:0][DATA_W-1:0] limWord;
  logic [CTRL_W-1:0]              ctrlReg;
  logic [FLAG_W-1:0]              enReg;
  logic [FLAG_W-1:0]              maskReg;
  logic                           clrWrite;

  for (genvar g = 0; g < N_PAIRS; g++) begin : g_lim
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) limWord[g] <= '0;
      else if (cfgWe && cfgAddr == ADDR_W'(g)) limWord[g] <= cfgWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      enReg   <= '0;
      maskReg <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == ADDR_CTRL) ctrlReg <= cfgWdata[CTRL_W-1:0];
      if (cfgAddr == ADDR_EN)   enReg   <= cfgWdata[FLAG_W-1:0];
      if (cfgAddr == ADDR_MASK) maskReg <= cfgWdata[FLAG_W-1:0];
    end
  end

  assign clrWrite = cfgWe && (cfgAddr == ADDR_CLR);
  assign intMask  = maskReg;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic [CHAN_W-1:0] srcChan;
    assign upLim[u]   = limWord[u/2][PAIR_W*(u%2) + LIM_W +: LIM_W];
    assign loLim[u]   = limWord[u/2][PAIR_W*(u%2) +: LIM_W];
    assign trigSel[u] = ctrlReg[2*u +: 2];
    assign srcChan    = ctrlReg[2*N_UNITS + CHAN_W*u +: CHAN_W];
    assign enLo[u]    = enReg[2*u];
    assign enHi[u]    = enReg[2*u+1];
    assign stb.evalStb[u] = resValid && (resChan == srcChan);
    assign stb.clrLo[u]   = clrWrite && cfgWdata[2*u];
    assign stb.clrHi[u]   = clrWrite && cfgWdata[2*u+1];

    p_idle_chan_r5: assert property (@(posedge clk) disable iff (!rstN)
      (resChan != srcChan) |-> !stb.evalStb[u]);
  end
endmodule

// File: rtl/adcwm_datapath.sv
module adcwm_datapath
  import adcwm_pkg::*;
#(
  parameter int N_UNITS = NUM_UNITS
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [RES_W-1:0]              resData,
  input  logic [N_UNITS-1:0][LIM_W-1:0] upLim,
  input  logic [N_UNITS-1:0][LIM_W-1:0] loLim,
  input  logic [N_UNITS-1:0][1:0]       trigSel,
  input  logic [N_UNITS-1:0]            enLo,
  input  logic [N_UNITS-1:0]            enHi,
  input  logic [FLAG_W-1:0]             intMask,
  input  strobes_t                      stb,
  output logic [N_UNITS-1:0]            rawLo,
  output logic [N_UNITS-1:0]            rawHi,
  output logic [N_UNITS-1:0]            statLo,
  output logic [N_UNITS-1:0]            statHi,
  output logic                          irq
);
  localparam int PAD_W = RES_W - LIM_W;

  logic [FLAG_W-1:0] statVec;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic [RES_W-1:0] hiRef;
    logic [RES_W-1:0] loRef;
    logic condHi, condLo, nowHi, nowLo, setHi, setLo;
    trig_e mode;

    // Widening the limit lets the full result be compared while only
    // its top byte decides: {up,FF} for upper, {lo,00} for lower.
    assign hiRef  = {upLim[u], {PAD_W{1'b1}}};
    assign loRef  = {loLim[u], {PAD_W{1'b0}}};
    assign condHi = $signed(resData) > $signed(hiRef);
    assign condLo = $signed(resData) < $signed(loRef);
    assign nowHi  = enHi[u] & condHi;
    assign nowLo  = enLo[u] & condLo;
    assign mode   = trig_e'(trigSel[u]);
    assign setHi  = stb.evalStb[u] & enHi[u] & edgeHit(mode, nowHi, rawHi[u]);
    assign setLo  = stb.evalStb[u] & enLo[u] & edgeHit(mode, nowLo, rawLo[u]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rawHi[u]  <= 1'b0;
        rawLo[u]  <= 1'b0;
        statHi[u] <= 1'b0;
        statLo[u] <= 1'b0;
      end else begin
        if (stb.evalStb[u]) begin
          rawHi[u] <= nowHi;
          rawLo[u] <= nowLo;
        end
        statHi[u] <= (statHi[u] & ~stb.clrHi[u]) | setHi;
        statLo[u] <= (statLo[u] & ~stb.clrLo[u]) | setLo;
      end
    end

    assign statVec[2*u]   = statLo[u];
    assign statVec[2*u+1] = statHi[u];

    p_raw_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      !stb.evalStb[u] |=> ($stable(rawHi[u]) && $stable(rawLo[u])));
    p_stat_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!stb.evalStb[u] && !stb.clrHi[u] && !stb.clrLo[u])
        |=> ($stable(statHi[u]) && $stable(statLo[u])));
    p_off_raw_r9: assert property (@(posedge clk) disable iff (!rstN)
      (stb.evalStb[u] && !enHi[u]) |=> !rawHi[u]);
    p_off_stat_r9: assert property (@(posedge clk) disable iff (!rstN)
      (stb.evalStb[u] && !enLo[u] && !statLo[u]) |=> !statLo[u]);
    p_level_r7: assert property (@(posedge clk) disable iff (!rstN)
      (stb.evalStb[u] && enHi[u] && mode == TRG_LEVEL &&
       $signed(resData[RES_W-1 -: LIM_W]) > $signed(upLim[u])) |=> statHi[u]);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
      (stb.clrHi[u] && !stb.evalStb[u]) |=> !statHi[u]);
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
      (statLo[u] && !stb.clrLo[u]) |=> statLo[u]);
  end

  assign irq = |(statVec & intMask);
endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
  import adcwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        resValid,
  input  logic [3:0]  resChan,
  input  logic [15:0] resData,
  input  logic        cfgWe,
  input  logic [2:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  output logic [3:0]  rawLo,
  output logic [3:0]  rawHi,
  output logic [3:0]  statLo,
  output logic [3:0]  statHi,
  output logic        irq
);
  logic [NUM_UNITS-1:0][LIM_W-1:0] upLim;
  logic [NUM_UNITS-1:0][LIM_W-1:0] loLim;
  logic [NUM_UNITS-1:0][1:0]       trigSel;
  logic [NUM_UNITS-1:0]            enLo;
  logic [NUM_UNITS-1:0]            enHi;
  logic [FLAG_W-1:0]               intMask;
  strobes_t                        stb;

  adcwm_ctrl #(.N_UNITS(NUM_UNITS)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .resValid(resValid), .resChan(resChan),
    .upLim(upLim), .loLim(loLim), .trigSel(trigSel), .enLo(enLo),
    .enHi(enHi), .intMask(intMask), .stb(stb)
  );

  adcwm_datapath #(.N_UNITS(NUM_UNITS)) uData (
    .clk(clk), .rstN(rstN), .resData(resData), .upLim(upLim),
    .loLim(loLim), .trigSel(trigSel), .enLo(enLo), .enHi(enHi),
    .intMask(intMask), .stb(stb), .rawLo(rawLo), .rawHi(rawHi),
    .statLo(statLo), .statHi(statHi), .irq(irq)
  );

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((statLo | statHi) != '0));
endmodule

// File: tb/adc_window_monitor_test.sv
module adc_window_monitor_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic [3:0]  resChan = '0;
  logic [15:0] resData = '0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [3:0]  rawLo, rawHi, statLo, statHi;
  logic        irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  string curReq = "R1";

  logic [7:0] mUp [4];
  logic [7:0] mLo [4];
  logic [1:0] mMode [4];
  logic [3:0] mSrc [4];
  logic [3:0] mEnLo, mEnHi, mRawLo, mRawHi, mStatLo, mStatHi;
  logic [7:0] mMask;

  adc_window_monitor uut (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan),
    .resData(resData), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .rawLo(rawLo), .rawHi(rawHi), .statLo(statLo), .statHi(statHi), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic hitF(logic [1:0] m, logic n, logic o);
    case (m)
      2'd0: return n;
      2'd1: return n & ~o;
      2'd2: return ~n & o;
      default: return n ^ o;
    endcase
  endfunction

  task automatic modelReset();
    for (int u = 0; u < 4; u++) begin
      mUp[u] = '0; mLo[u] = '0; mMode[u] = '0; mSrc[u] = '0;
    end
    mEnLo = '0; mEnHi = '0; mRawLo = '0; mRawHi = '0;
    mStatLo = '0; mStatHi = '0; mMask = '0;
  endtask

  task automatic modelStep();
    logic [3:0] setLo, setHi, clrLo, clrHi;
    setLo = '0; setHi = '0; clrLo = '0; clrHi = '0;
    for (int u = 0; u < 4; u++) begin
      if (resValid && resChan == mSrc[u]) begin
        logic signed [7:0] hb;
        logic nh, nl;
        hb = $signed(resData[15:8]);
        nh = mEnHi[u] && (hb > $signed(mUp[u]));
        nl = mEnLo[u] && (hb < $signed(mLo[u]));
        setHi[u] = mEnHi[u] && hitF(mMode[u], nh, mRawHi[u]);
        setLo[u] = mEnLo[u] && hitF(mMode[u], nl, mRawLo[u]);
        mRawHi[u] = nh;
        mRawLo[u] = nl;
      end
      if (cfgWe && cfgAddr == 3'd5) begin
        clrLo[u] = cfgWdata[2*u];
        clrHi[u] = cfgWdata[2*u+1];
      end
    end
    mStatLo = (mStatLo & ~clrLo) | setLo;
    mStatHi = (mStatHi & ~clrHi) | setHi;
    if (cfgWe) begin
      case (cfgAddr)
        3'd0: begin mLo[0] = cfgWdata[7:0]; mUp[0] = cfgWdata[15:8];
                    mLo[1] = cfgWdata[23:16]; mUp[1] = cfgWdata[31:24]; end
        3'd1: begin mLo[2] = cfgWdata[7:0]; mUp[2] = cfgWdata[15:8];
                    mLo[3] = cfgWdata[23:16]; mUp[3] = cfgWdata[31:24]; end
        3'd2: for (int u = 0; u < 4; u++) begin
                mMode[u] = cfgWdata[2*u +: 2];
                mSrc[u]  = cfgWdata[8 + 4*u +: 4];
              end
        3'd3: for (int u = 0; u < 4; u++) begin
                mEnLo[u] = cfgWdata[2*u];
                mEnHi[u] = cfgWdata[2*u+1];
              end
        3'd4: mMask = cfgWdata[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic checkOut();
    logic expIrq;
    logic [16:0] act, exp;
    expIrq = 1'b0;
    for (int u = 0; u < 4; u++)
      expIrq |= (mStatLo[u] & mMask[2*u]) | (mStatHi[u] & mMask[2*u+1]);
    act = {rawHi, rawLo, statHi, statLo, irq};
    exp = {mRawHi, mRawLo, mStatHi, mStatLo, expIrq};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {rawHi,rawLo,statHi,statLo,irq} actual %h expected %h",
               curReq, act, exp);
    end
  endtask

  // Inputs are held from the previous falling edge; the model steps at the
  // rising edge, and outputs are compared at the following falling edge.
  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    resValid = 1'b0; cfgWe = 1'b0;
    checkOut();
  endtask

  task automatic cfgWrite(logic [2:0] a, logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    tick();
  endtask

  task automatic sample(logic [3:0] ch, logic [15:0] d, bit withClr, logic [7:0] clr);
    resValid = 1'b1; resChan = ch; resData = d;
    if (withClr) begin cfgWe = 1'b1; cfgAddr = 3'd5; cfgWdata = {24'd0, clr}; end
    tick();
  endtask

  initial begin
    logic [7:0] enPat [4];
    logic [7:0] maskPat [4];
    logic [31:0] ctrlWord;
    enPat[0] = 8'hFF; enPat[1] = 8'h55; enPat[2] = 8'hAA; enPat[3] = 8'h00;
    maskPat[0] = 8'hFF; maskPat[1] = 8'h0F; maskPat[2] = 8'hA5; maskPat[3] = 8'hC3;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    checkOut();

    curReq = "R2 R4";
    // unit0 up 40 lo -40, unit1 up 0 lo 0, unit2 up 100 lo 50, unit3 up 16 lo -16
    cfgWrite(3'd0, {8'h00, 8'h00, 8'd40, 8'hD8});
    cfgWrite(3'd1, {8'h10, 8'hF0, 8'd100, 8'd50});

    for (int m = 0; m < 4; m++) begin
      ctrlWord = '0;
      for (int u = 0; u < 4; u++) begin
        ctrlWord[2*u +: 2] = 2'((m + u) % 4);
        ctrlWord[8 + 4*u +: 4] = 4'((u * 5 + m) % 16);
      end
      curReq = "R3 R8";
      cfgWrite(3'd2, ctrlWord);
      for (int e = 0; e < 4; e++) begin
        curReq = "R3 R11";
        cfgWrite(3'd3, {24'd0, enPat[e]});
        cfgWrite(3'd4, {24'd0, maskPat[(e + m) % 4]});
        curReq = "R4 R5 R6 R7 R8 R9 R10 R11";
        for (int i = 0; i < 128; i++) begin
          logic [7:0] hb;
          hb = 8'((i + 128 * (e % 2)) * 29 + m * 3);
          sample(4'((i * 3 + e) % 16), {hb, 8'(i * 7)}, (i % 7) == 6, 8'(i * 13));
          if ((i % 11) == 10) cfgWrite(3'd5, {24'd0, 8'(i * 37)});
        end
      end
    end

    curReq = "R3 R10";
    cfgWrite(3'd6, 32'hFFFF_FFFF);
    cfgWrite(3'd7, 32'hFFFF_FFFF);
    cfgWrite(3'd5, 32'h0000_0000);
    curReq = "R3 R5 R6 R7";
    for (int i = 0; i < 32; i++)
      sample(4'(i % 16), {8'(i * 41), 8'h00}, 1'b0, 8'h00);
    curReq = "R10";
    cfgWrite(3'd5, 32'h0000_00FF);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule